// File: doc/BRIEF.md
# Multi-Cycle Multiply-Accumulate Engine

This block carries out integer multiplies and multiply-accumulates for a processor core. A decoded 16-bit instruction word and two operand values arrive with a one-cycle start strobe. The engine works for a fixed number of cycles chosen by the operation, pulses done, and leaves the result in a double-width accumulator. The accumulator is exposed as an upper half and a lower half. Plain multiplies write only the lower half. The accumulating forms add a full signed product into the whole double-width value, wrapping on overflow.

Five operations are recognised:
- a full-width multiply that keeps the low word of the product;
- signed and unsigned multiplies of the low halfwords;
- signed full-width multiply-accumulate;
- signed halfword multiply-accumulate.

The engine has these parameters:
- the data width, with the accumulator twice as wide;
- the latency of each operation class;
- whether one shared sign-extended multiplier is built or separate full-width and halfword multipliers.

A synchronous clear zeroes the accumulator between accumulation runs.

Top module: `mac_unit`

## Requirements
- R1: After reset, busy and done are low and both accumulator halves read zero.
- R2: Opcode bits [15:12]=0000 with bits [3:0]=0111 multiply the full operands. The low data-width bits of the product go to the lower half, and the upper half keeps its value. Latency is LAT_MUL_W (default 2).
- R3: Bits [15:12]=0010 with [3:0]=1111 multiply the low halfwords of both operands as signed values. The data-width product goes to the lower half, and the upper half is unchanged. Latency is LAT_MUL_H (default 1).
- R4: Bits [15:12]=0010 with [3:0]=1110 do the same halfword multiply as R3 but treat both halfwords as unsigned. The upper half is unchanged and the latency is LAT_MUL_H.
- R5: Bits [15:12]=0000 with [3:0]=1111 add the signed full-width product to the whole accumulator, modulo 2^(2·DW). Latency is LAT_MAC (default 3).
- R6: Bits [15:12]=0100 with [3:0]=1111 sign-extend the signed halfword product to the accumulator width and add it modulo 2^(2·DW). Latency is LAT_MAC.
- R7: Start is accepted on a clock edge. Call the latency L. Busy is high for the L cycles after that edge. Done is high for exactly one cycle, the one that starts L edges after acceptance, and busy is low in that cycle. The new accumulator value is visible from that same cycle. A new start may be accepted while done is high.
- R8: A start that arrives while busy is high is ignored. It changes neither the result nor the timing of the operation in progress.
- R9: A start whose opcode matches none of the five encodings is ignored. Busy and done stay low and the accumulator is unchanged.
- R10: Clear zeroes both accumulator halves at the next edge. It takes priority over a result written at that same edge.
- R11: Opcode bits [11:4] do not affect the operation or its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous accumulator clear |
| start | input | 1 | Start strobe, sampled at the clock edge |
| opcode | input | 16 | Decoded instruction word |
| src_a | input | DW | First operand |
| src_b | input | DW | Second operand |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| acc_hi | output | DW | Upper half of the accumulator |
| acc_lo | output | DW | Lower half of the accumulator |

## Verification
The assertions check the handshake on every cycle:
- done is a lone pulse, and busy is low while done is high;
- busy ends only through done;
- an accepted opcode raises busy, and an unknown opcode leaves it low;
- the accumulator moves only on completion or after a clear, and clear zeroes it;
- the upper half holds across the lower-half-only multiplies.

Only the bench's scenarios can show that the arithmetic is right. They sweep operand values and compare results against products computed in the bench, with signed and unsigned halfwords and accumulation wrapping through the upper half. They also show the exact latency of each opcode, a start that is ignored while busy, and clear winning over a result written at the same edge.

// File: rtl/mac_pkg.sv
package mac_pkg;

   typedef enum logic [2:0] {
      OP_NONE   = 3'd0,
      OP_MUL_W  = 3'd1,
      OP_MULS_H = 3'd2,
      OP_MULU_H = 3'd3,
      OP_MAC_W  = 3'd4,
      OP_MAC_H  = 3'd5
   } mac_op_e;

   localparam logic [7:0] ENC_MUL_W  = 8'b0000_0111;
   localparam logic [7:0] ENC_MULS_H = 8'b0010_1111;
   localparam logic [7:0] ENC_MULU_H = 8'b0010_1110;
   localparam logic [7:0] ENC_MAC_W  = 8'b0000_1111;
   localparam logic [7:0] ENC_MAC_H  = 8'b0100_1111;

   function automatic logic op_is_accum(input mac_op_e op);
      return (op == OP_MAC_W) || (op == OP_MAC_H);
   endfunction

endpackage

// File: rtl/mac_decode.sv
module mac_decode
   import mac_pkg::*;
(
   input  logic [7:0] enc,
   output mac_op_e    op,
   output logic       valid
);

   always_comb begin
      case (enc)
         ENC_MUL_W:  op = OP_MUL_W;
         ENC_MULS_H: op = OP_MULS_H;
         ENC_MULU_H: op = OP_MULU_H;
         ENC_MAC_W:  op = OP_MAC_W;
         ENC_MAC_H:  op = OP_MAC_H;
         default:    op = OP_NONE;
      endcase
   end

   assign valid = (op != OP_NONE);

endmodule

// File: rtl/mac_ctrl.sv
module mac_ctrl
   import mac_pkg::*;
#(
   parameter int LAT_MUL_W = 2,
   parameter int LAT_MUL_H = 1,
   parameter int LAT_MAC   = 3,
   parameter int CNT_W     = 2
)(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    start,
   input  logic    valid,
   input  mac_op_e op_in,
   output logic    accept,
   output logic    fin,
   output mac_op_e op_q,
   output logic    busy,
   output logic    done
);

   logic             busy_q;
   logic             done_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] lat_sel;

   always_comb begin
      case (op_in)
         OP_MUL_W:            lat_sel = CNT_W'(LAT_MUL_W);
         OP_MULS_H, OP_MULU_H: lat_sel = CNT_W'(LAT_MUL_H);
         default:             lat_sel = CNT_W'(LAT_MAC);
      endcase
   end

   assign accept = start && valid && !busy_q;
   assign fin    = busy_q && (cnt_q == CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         cnt_q  <= '0;
         op_q   <= OP_NONE;
      end else begin
         done_q <= fin;
         if (accept) begin
            busy_q <= 1'b1;
            cnt_q  <= lat_sel;
            op_q   <= op_in;
         end else if (busy_q) begin
            cnt_q <= cnt_q - CNT_W'(1);
            if (fin) begin
               busy_q <= 1'b0;
            end
         end
      end
   end

   assign busy = busy_q;
   assign done = done_q;

endmodule

// File: rtl/mac_mult.sv
module mac_mult
   import mac_pkg::*;
#(
   parameter int DW         = 32,
   parameter bit SHARED_MUL = 1'b1
)(
   input  mac_op_e           op,
   input  logic [DW-1:0]     a,
   input  logic [DW-1:0]     b,
   output logic [2*DW-1:0]   prod
);

   localparam int HW = DW / 2;
   localparam int AW = 2 * DW;

   generate
      if (SHARED_MUL) begin : g_shared
         logic [AW-1:0] xa;
         logic [AW-1:0] xb;

         always_comb begin
            case (op)
               OP_MUL_W, OP_MAC_W: begin
                  xa = AW'($signed(a));
                  xb = AW'($signed(b));
               end
               OP_MULS_H, OP_MAC_H: begin
                  xa = AW'($signed(a[HW-1:0]));
                  xb = AW'($signed(b[HW-1:0]));
               end
               OP_MULU_H: begin
                  xa = AW'(a[HW-1:0]);
                  xb = AW'(b[HW-1:0]);
               end
               default: begin
                  xa = '0;
                  xb = '0;
               end
            endcase
         end

         assign prod = xa * xb;
      end else begin : g_split
         logic [AW-1:0] p_w;
         logic [DW-1:0] p_hs;
         logic [DW-1:0] p_hu;

         assign p_w  = AW'($signed(a)) * AW'($signed(b));
         assign p_hs = DW'($signed(a[HW-1:0])) * DW'($signed(b[HW-1:0]));
         assign p_hu = DW'(a[HW-1:0]) * DW'(b[HW-1:0]);

         always_comb begin
            case (op)
               OP_MUL_W, OP_MAC_W:   prod = p_w;
               OP_MULS_H, OP_MAC_H:  prod = AW'($signed(p_hs));
               OP_MULU_H:            prod = AW'(p_hu);
               default:              prod = '0;
            endcase
         end
      end
   endgenerate

endmodule

// File: rtl/mac_acc.sv
module mac_acc
   import mac_pkg::*;
#(
   parameter int DW = 32
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr,
   input  logic            fin,
   input  mac_op_e         op,
   input  logic [2*DW-1:0] prod,
   output logic [DW-1:0]   hi,
   output logic [DW-1:0]   lo
);

   logic [2*DW-1:0] sum;

   assign sum = {hi, lo} + prod;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi <= '0;
         lo <= '0;
      end else if (clr) begin
         hi <= '0;
         lo <= '0;
      end else if (fin) begin
         if (op_is_accum(op)) begin
            {hi, lo} <= sum;
         end else begin
            lo <= prod[DW-1:0];
         end
      end
   end

endmodule

// File: rtl/mac_unit.sv
module mac_unit
   import mac_pkg::*;
#(
   parameter int DW         = 32,
   parameter int LAT_MUL_W  = 2,
   parameter int LAT_MUL_H  = 1,
   parameter int LAT_MAC    = 3,
   parameter bit SHARED_MUL = 1'b1
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          start,
   input  logic [15:0]   opcode,
   input  logic [DW-1:0] src_a,
   input  logic [DW-1:0] src_b,
   output logic          busy,
   output logic          done,
   output logic [DW-1:0] acc_hi,
   output logic [DW-1:0] acc_lo
);

   localparam int AW    = 2 * DW;
   localparam int MAX_A = (LAT_MUL_W > LAT_MUL_H) ? LAT_MUL_W : LAT_MUL_H;
   localparam int MAX_L = (MAX_A > LAT_MAC) ? MAX_A : LAT_MAC;
   localparam int CNT_W = $clog2(MAX_L + 1);

   generate
      if ((DW < 2) || ((DW % 2) != 0)) begin : g_bad_dw
         $error("mac_unit: DW must be even and at least 2");
      end
      if ((LAT_MUL_W < 1) || (LAT_MUL_H < 1) || (LAT_MAC < 1)) begin : g_bad_lat
         $error("mac_unit: every latency must be at least 1");
      end
   endgenerate

   mac_op_e       dec_op;
   logic          dec_valid;
   logic          accept;
   logic          fin;
   mac_op_e       op_q;
   logic [DW-1:0] a_q;
   logic [DW-1:0] b_q;
   logic [AW-1:0] prod;

   mac_decode u_decode (
      .enc   ({opcode[15:12], opcode[3:0]}),
      .op    (dec_op),
      .valid (dec_valid)
   );

   mac_ctrl #(
      .LAT_MUL_W (LAT_MUL_W),
      .LAT_MUL_H (LAT_MUL_H),
      .LAT_MAC   (LAT_MAC),
      .CNT_W     (CNT_W)
   ) u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .valid  (dec_valid),
      .op_in  (dec_op),
      .accept (accept),
      .fin    (fin),
      .op_q   (op_q),
      .busy   (busy),
      .done   (done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q <= '0;
         b_q <= '0;
      end else if (accept) begin
         a_q <= src_a;
         b_q <= src_b;
      end
   end

   mac_mult #(
      .DW         (DW),
      .SHARED_MUL (SHARED_MUL)
   ) u_mult (
      .op   (op_q),
      .a    (a_q),
      .b    (b_q),
      .prod (prod)
   );

   mac_acc #(
      .DW (DW)
   ) u_acc (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .fin   (fin),
      .op    (op_q),
      .prod  (prod),
      .hi    (acc_hi),
      .lo    (acc_lo)
   );

endmodule

// File: rtl/mac_unit_chk.sv
module mac_unit_chk #(
   parameter int DW = 32
)(
   input logic          clk,
   input logic          rst_n,
   input logic          clr,
   input logic          start,
   input logic [15:0]   opcode,
   input logic [DW-1:0] src_a,
   input logic [DW-1:0] src_b,
   input logic          busy,
   input logic          done,
   input logic [DW-1:0] acc_hi,
   input logic [DW-1:0] acc_lo
);

   logic [7:0] enc;
   logic       known;
   logic       lo_only;
   logic       lo_only_q;

   assign enc     = {opcode[15:12], opcode[3:0]};
   assign lo_only = (enc == 8'b0000_0111) || (enc == 8'b0010_1111) ||
                    (enc == 8'b0010_1110);
   assign known   = lo_only || (enc == 8'b0000_1111) || (enc == 8'b0100_1111);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_only_q <= 1'b0;
      end else if (start && !busy && known) begin
         lo_only_q <= lo_only;
      end
   end

   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy); // R7
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R7
   AST_BUSY_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (busy || done)); // R7
   AST_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && known) |=> busy); // R7
   AST_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && !known) |=> !busy); // R9
   AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> ((acc_hi == '0) && (acc_lo == '0))); // R10
   AST_ACC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!done && !$past(clr)) |-> $stable({acc_hi, acc_lo})); // R5
   AST_HI_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (done && lo_only_q && !$past(clr)) |-> $stable(acc_hi)); // R2
   AST_INPUT_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !$isunknown({opcode, src_a, src_b})); // R11

endmodule

bind mac_unit mac_unit_chk #(.DW(DW)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .clr    (clr),
   .start  (start),
   .opcode (opcode),
   .src_a  (src_a),
   .src_b  (src_b),
   .busy   (busy),
   .done   (done),
   .acc_hi (acc_hi),
   .acc_lo (acc_lo)
);

// File: tb/mac_unit_bench.sv
module mac_unit_bench;

   localparam int DW = 8;
   localparam int AW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          clr = 1'b0;
   logic          start = 1'b0;
   logic [15:0]   opcode = '0;
   logic [DW-1:0] src_a = '0;
   logic [DW-1:0] src_b = '0;
   logic          busy;
   logic          done;
   logic [DW-1:0] acc_hi;
   logic [DW-1:0] acc_lo;

   int            checks = 0;
   int            fails  = 0;
   logic [AW-1:0] model  = '0;

   always #10 clk = ~clk;

   mac_unit #(.DW(DW)) u_mac_unit (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (clr),
      .start  (start),
      .opcode (opcode),
      .src_a  (src_a),
      .src_b  (src_b),
      .busy   (busy),
      .done   (done),
      .acc_hi (acc_hi),
      .acc_lo (acc_lo)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic int sx(input int v, input int bits);
      return (v >= (1 << (bits - 1))) ? v - (1 << bits) : v;
   endfunction

   // kind: 0 full mul, 1 signed half mul, 2 unsigned half mul, 3 full mac, 4 half mac
   function automatic logic [7:0] enc_of(input int kind);
      case (kind)
         0:       return 8'b0000_0111;
         1:       return 8'b0010_1111;
         2:       return 8'b0010_1110;
         3:       return 8'b0000_1111;
         default: return 8'b0100_1111;
      endcase
   endfunction

   function automatic int lat_of(input int kind);
      case (kind)
         0:       return 2;
         1, 2:    return 1;
         default: return 3;
      endcase
   endfunction

   function automatic string req_of(input int kind);
      case (kind)
         0:       return "R2";
         1:       return "R3";
         2:       return "R4";
         3:       return "R5";
         default: return "R6";
      endcase
   endfunction

   task automatic model_step(input int kind, input int a, input int b);
      case (kind)
         0: model[7:0] = 8'(a * b);
         1: model[7:0] = 8'(sx(a & 15, 4) * sx(b & 15, 4));
         2: model[7:0] = 8'((a & 15) * (b & 15));
         3: model = model + 16'(sx(a, 8) * sx(b, 8));
         default: model = model + 16'(sx(a & 15, 4) * sx(b & 15, 4));
      endcase
   endtask

   task automatic drive(input int kind, input int a, input int b, input logic [7:0] fld);
      logic [7:0] e;
      e = enc_of(kind);
      start  = 1'b1;
      opcode = {e[7:4], fld, e[3:0]};
      src_a  = DW'(a);
      src_b  = DW'(b);
   endtask

   task automatic run(input int kind, input int a, input int b, input logic [7:0] fld);
      int  lat;
      bit  tim_ok;
      lat = lat_of(kind);
      @(negedge clk);
      drive(kind, a, b, fld);
      @(negedge clk);
      start  = 1'b0;
      tim_ok = 1'b1;
      for (int k = 1; k <= lat; k++) begin
         if (k > 1) @(negedge clk);
         tim_ok &= busy && !done;
      end
      @(negedge clk);
      tim_ok &= done && !busy;
      check(tim_ok, {req_of(kind), "/R7 latency"}, {30'd0, busy, done}, 32'd1);
      model_step(kind, a, b);
      check({acc_hi, acc_lo} == model, {req_of(kind), "/R11 result"},
            {16'd0, acc_hi, acc_lo}, {16'd0, model});
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check(!busy && !done && acc_hi == '0 && acc_lo == '0, "R1",
            {14'd0, busy, done, acc_hi, acc_lo}, 32'd0);

      // R5/R2: full-width sweep, accumulation wraps through the upper half
      for (int a = 0; a < 256; a += 7) begin
         for (int b = 0; b < 256; b += 5) begin
            run(3, a, b, 8'(a + b));
            run(0, b, a, 8'(a ^ b));
         end
      end

      // R3/R4/R6: exhaustive halfword sweep
      for (int a = 0; a < 16; a++) begin
         for (int b = 0; b < 16; b++) begin
            run(1, a | 8'hA0, b | 8'h50, 8'(a * 16 + b));
            run(2, a | 8'h30, b | 8'hC0, 8'(b * 16 + a));
            run(4, a, b | 8'hF0, 8'(a));
         end
      end

      // R11: register fields all-zero versus all-one give the same result
      run(2, 8'h0F, 8'h0D, 8'h00);
      run(2, 8'h0F, 8'h0D, 8'hFF);

      // R9: unknown opcodes are ignored
      begin
         logic [15:0] bad [3];
         bad[0] = 16'b0001_0000_0000_0111;
         bad[1] = 16'b0010_0000_0000_1101;
         bad[2] = 16'b0100_1010_0101_1110;
         for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            start  = 1'b1;
            opcode = bad[i];
            src_a  = 8'h77;
            src_b  = 8'h99;
            @(negedge clk);
            start = 1'b0;
            check(!busy && !done, "R9 busy", {30'd0, busy, done}, 32'd0);
            repeat (3) @(negedge clk);
            check(!done && {acc_hi, acc_lo} == model, "R9 acc",
                  {15'd0, done, acc_hi, acc_lo}, {16'd0, model});
         end
      end

      // R8: start while busy is ignored
      @(negedge clk);
      drive(3, 5, 7, 8'h12);
      @(negedge clk);
      drive(0, 255, 255, 8'h34);
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      check(busy && !done, "R8 timing", {30'd0, busy, done}, 32'd2);
      @(negedge clk);
      model_step(3, 5, 7);
      check(done && {acc_hi, acc_lo} == model, "R8 result",
            {15'd0, done, acc_hi, acc_lo}, {15'd1, model});
      @(negedge clk);
      check(!busy && !done, "R8 no second run", {30'd0, busy, done}, 32'd0);

      // R10: clear while idle
      @(negedge clk);
      clr = 1'b1;
      @(negedge clk);
      clr   = 1'b0;
      model = '0;
      check(acc_hi == '0 && acc_lo == '0, "R10 idle", {16'd0, acc_hi, acc_lo}, 32'd0);
      run(4, 8'h07, 8'h05, 8'h00);
      run(3, 8'h80, 8'h7F, 8'h00);

      // R10: clear wins over a result written at the same edge
      @(negedge clk);
      drive(3, 100, 100, 8'h00);
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      @(negedge clk);
      clr = 1'b1;
      @(negedge clk);
      clr   = 1'b0;
      model = '0;
      check(done && acc_hi == '0 && acc_lo == '0, "R10 priority",
            {15'd0, done, acc_hi, acc_lo}, 32'h10000);

      run(1, 8'h0F, 8'h08, 8'h00);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

endmodule